// File: doc/BRIEF.md
# Fixed-Priority Hold-Until-Release Arbiter

This block hands one shared resource to one of several requesters (three by default). It is a Moore state machine with a rest state and one ownership state per requester. From the rest state it grants the highest-priority active request on the next clock edge. Requester 0 has the highest priority, then 1, then 2. Once granted, a requester keeps the resource for as long as its request stays high. Nobody can take the grant away from it, however urgent their own request is.

When the owner drops its request, the machine goes back to rest for exactly one cycle. Only then can another requester win. Grants come straight from the state register, so they change only on a clock edge and never follow request glitches inside a cycle.

A parameter selects how the state is encoded, either dense binary or one-hot. Any code that does not name a legal state is read as the rest state, so the next edge restores a legal code.

Top module: `arb_hold_fsm`

## Requirements
- R1: A clock edge with `rst_n` low (synchronous, active low) leaves all grants at 0 after that edge, whatever the requests are.
- R2: In the rest state (all grants 0), `req[0]`=1 sets `gnt[0]` at the next edge, whatever `req[1]` and `req[2]` are.
- R3: In the rest state, `req[0]`=0 with `req[1]`=1 sets `gnt[1]` at the next edge, whatever `req[2]` is.
- R4: In the rest state, `req[2]`=1 with `req[0]`=`req[1]`=0 sets `gnt[2]` at the next edge.
- R5: In the rest state with no request high, all grants stay 0 after the next edge.
- R6: An owner whose request is still high at an edge keeps its grant after that edge, even when a higher-priority request is high (no preemption).
- R7: An owner whose request is low at an edge loses its grant, and all grants are 0 after that edge even if other requests are pending. A new grant can appear one edge later at the earliest.
- R8: At most one bit of `gnt` is high in any cycle.
- R9: `gnt[i]` is high only if `req[i]` was high at the edge that produced it.
- R10: Grants depend on state only. Changing `req` between edges leaves `gnt` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_REQ | Request lines, bit 0 has the highest priority |
| gnt | output | NUM_REQ | One-hot grant lines, all 0 in the rest state |

## Verification
Every grant decision is due one edge after the requests it was based on. That holds for a new grant (R2–R4), for holding a grant (R6), for releasing one (R7) and for reset (R1). Requests are driven on the falling edge, and grants are compared on the following falling edge against a reference updated at the rising edge in between. A release is therefore seen as one cycle of all-zero grants, with the next winner due a further edge later. For R10 the requests are changed a few time units after a falling edge, and the grants are compared again before the next rising edge.

// File: rtl/arb_hold_pkg.sv
package arb_hold_pkg;

   typedef enum int {
      ENC_BINARY = 0,
      ENC_ONEHOT = 1
   } arb_enc_e;

   localparam int ARB_MIN_REQ = 2;
   localparam int ARB_MAX_REQ = 16;

endpackage

// File: rtl/arb_next.sv
// Next-state selection. Index 0 means the rest state; index k means requester k-1 owns the resource.
module arb_next #(
   parameter int NUM_REQ = 3,
   parameter int IW      = $clog2(NUM_REQ + 1)
) (
   input  logic [NUM_REQ-1:0] req,
   input  logic [NUM_REQ-1:0] gnt,
   input  logic [IW-1:0]      cur_idx,
   output logic [IW-1:0]      nxt_idx
);

   logic [IW-1:0] pick_idx;
   logic          owner_keeps;

   // Scan from the lowest priority upwards, so the last hit is the highest priority.
   always_comb begin
      pick_idx = '0;
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
         if (req[i]) pick_idx = IW'(i + 1);
      end
   end

   assign owner_keeps = |(req & gnt);

   always_comb begin
      if (cur_idx == '0)
         nxt_idx = pick_idx;
      else if (owner_keeps)
         nxt_idx = cur_idx;
      else
         nxt_idx = '0;
   end

endmodule

// File: rtl/arb_state.sv
// State register. The encoding variant is picked by a parameter; illegal codes decode to the rest state.
module arb_state
   import arb_hold_pkg::*;
#(
   parameter int       NUM_REQ = 3,
   parameter int       IW      = $clog2(NUM_REQ + 1),
   parameter arb_enc_e ENC     = ENC_BINARY
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] nxt_idx,
   output logic [IW-1:0] cur_idx
);

   localparam int NSTATE = NUM_REQ + 1;

   generate
      if (ENC == ENC_ONEHOT) begin : g_onehot
         logic [NSTATE-1:0] oh_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               oh_q <= NSTATE'(1);
            else
               oh_q <= NSTATE'(1) << nxt_idx;
         end

         always_comb begin
            cur_idx = '0;
            if ($onehot(oh_q)) begin
               for (int i = 1; i < NSTATE; i++) begin
                  if (oh_q[i]) cur_idx = IW'(i);
               end
            end
         end
      end else begin : g_binary
         logic [IW-1:0] bin_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               bin_q <= '0;
            else
               bin_q <= nxt_idx;
         end

         assign cur_idx = (32'(bin_q) < NSTATE) ? bin_q : '0;
      end
   endgenerate

endmodule

// File: rtl/arb_grant_dec.sv
// Moore output decode: each grant line follows its own state only.
module arb_grant_dec #(
   parameter int NUM_REQ = 3,
   parameter int IW      = $clog2(NUM_REQ + 1)
) (
   input  logic [IW-1:0]      cur_idx,
   output logic [NUM_REQ-1:0] gnt
);

   generate
      for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
         assign gnt[g] = (cur_idx == IW'(g + 1));
      end
   endgenerate

endmodule

// File: rtl/arb_hold_fsm.sv
module arb_hold_fsm
   import arb_hold_pkg::*;
#(
   parameter int       NUM_REQ = 3,
   parameter arb_enc_e ENC     = ENC_BINARY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req,
   output logic [NUM_REQ-1:0] gnt
);

   localparam int IW = $clog2(NUM_REQ + 1);

   generate
      if (NUM_REQ < ARB_MIN_REQ || NUM_REQ > ARB_MAX_REQ) begin : g_bad_count
         $error("arb_hold_fsm: NUM_REQ out of supported range");
      end
      if (ENC != ENC_BINARY && ENC != ENC_ONEHOT) begin : g_bad_enc
         $error("arb_hold_fsm: unknown state encoding");
      end
   endgenerate

   logic [IW-1:0] cur_idx;
   logic [IW-1:0] nxt_idx;

   arb_next #(.NUM_REQ(NUM_REQ), .IW(IW)) u_next (
      .req     (req),
      .gnt     (gnt),
      .cur_idx (cur_idx),
      .nxt_idx (nxt_idx)
   );

   arb_state #(.NUM_REQ(NUM_REQ), .IW(IW), .ENC(ENC)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_idx (nxt_idx),
      .cur_idx (cur_idx)
   );

   arb_grant_dec #(.NUM_REQ(NUM_REQ), .IW(IW)) u_dec (
      .cur_idx (cur_idx),
      .gnt     (gnt)
   );

endmodule

// File: rtl/arb_hold_chk.sv
module arb_hold_chk #(
   parameter int NUM_REQ = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] req,
   input logic [NUM_REQ-1:0] gnt
);

   // R1: an edge in reset clears every grant
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (gnt == '0));

   // R5: rest state with no request stays at rest
   assert_rest_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0) |=> (gnt == '0));

   // R8: never more than one grant
   assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
         localparam logic [NUM_REQ-1:0] HIGHER = NUM_REQ'((1 << i) - 1);

         if (i == 0) begin : g_p0
            // R2: top priority wins from rest
            assert_prio_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
               (gnt == '0 && req[0]) |=> gnt[0]);
         end else if (i == 1) begin : g_p1
            // R3: second priority wins when the top one is idle
            assert_prio_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (gnt == '0 && req[1] && !req[0]) |=> gnt[1]);
         end else begin : g_pn
            // R4: lower priorities win only with every higher one idle
            assert_prio_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (gnt == '0 && req[i] && ((req & HIGHER) == '0)) |=> gnt[i]);
         end

         // R6: owner with its request high keeps the grant
         assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && req[i]) |=> gnt[i]);

         // R7: owner that releases returns to rest for a cycle
         assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && !req[i]) |=> (gnt == '0));

         // R9: a grant always stems from its own request at the previous edge
         assert_grant_has_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gnt[i]) |-> $past(req[i]));
      end
   endgenerate

endmodule

bind arb_hold_fsm arb_hold_chk #(.NUM_REQ(NUM_REQ)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .req   (req),
   .gnt   (gnt)
);

// File: tb/sim_arb_hold_fsm.sv
module sim_arb_hold_fsm;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 3;
   localparam int WATCHDOG   = 200000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] gnt;

   int total = 0;
   int bad   = 0;
   int exp_idx = 0;   // 0 = rest, k = requester k-1 owns
   logic [N-1:0] last_req = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   arb_hold_fsm #(.NUM_REQ(N)) u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .gnt   (gnt)
   );

   function automatic int ref_next(int cur, logic [N-1:0] r, logic rn);
      if (!rn) return 0;
      if (cur == 0) begin
         for (int i = 0; i < N; i++) if (r[i]) return i + 1;
         return 0;
      end
      return r[cur-1] ? cur : 0;
   endfunction

   function automatic logic [N-1:0] ref_gnt(int idx);
      return (idx == 0) ? '0 : N'(1 << (idx - 1));
   endfunction

   function automatic string tag_for(int cur, logic [N-1:0] r, logic rn);
      if (!rn) return "R1";
      if (cur != 0) return r[cur-1] ? "R6" : "R7";
      if (r[0]) return "R2";
      if (r[1]) return "R3";
      if (r[2]) return "R4";
      return "R5";
   endfunction

   task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, reference moves at rising edge, compare at next falling edge
   task automatic step(logic [N-1:0] r, logic rn);
      string tag;
      req   = r;
      rst_n = rn;
      tag   = tag_for(exp_idx, r, rn);
      @(posedge clk);
      exp_idx  = ref_next(exp_idx, r, rn);
      last_req = r;
      @(negedge clk);
      check(tag, gnt, ref_gnt(exp_idx));
      total++;
      if (!$onehot0(gnt)) begin
         bad++;
         $display("FAIL R8: gnt actual=%b expected=at most one bit", gnt);
      end
      total++;
      if ((gnt & ~last_req) != '0) begin
         bad++;
         $display("FAIL R9: gnt actual=%b expected subset of req=%b", gnt, last_req);
      end
   endtask

   task automatic mid_cycle_glitch();
      logic [N-1:0] held;
      held = gnt;
      req = ~req;
      #2;
      req = ~req;
      #1;
      req = N'(3'b111);
      #1;
      check("R10", gnt, held);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      step(3'b111, 1'b0);                 // R1 reset with requests pending
      step(3'b000, 1'b1);                 // R5 idle stays idle
      step(3'b111, 1'b1);                 // R2 top wins
      step(3'b111, 1'b1);                 // R6 held
      step(3'b110, 1'b1);                 // R7 release, others pending
      step(3'b110, 1'b1);                 // R3 mid wins
      step(3'b011, 1'b1);                 // R6 no preemption by top
      mid_cycle_glitch();                 // R10
      step(3'b101, 1'b1);                 // R7 release
      step(3'b100, 1'b1);                 // R4 low wins
      step(3'b101, 1'b1);                 // R6 held against top
      step(3'b100, 1'b0);                 // R1 reset while owning
      step(3'b100, 1'b1);                 // R4 again from rest

      for (int c = 0; c < 3000; c++) begin
         logic [N-1:0] r;
         logic rn;
         r  = N'($urandom);
         if (($urandom % 4) != 0 && exp_idx != 0) r[exp_idx-1] = 1'b1;  // favour long holds
         rn = (($urandom % 97) != 0);
         step(r, rn);
         if ((c % 50) == 0) mid_cycle_glitch();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule